// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the wire-level engine of a two-pin debug host. One command from the host logic runs exactly one register access on the debug port or an access port of a target. The engine builds the 8-slot request header, hands the data line over to the target for the acknowledge, and then either collects 32 read bits plus parity or drives 32 write bits plus parity. It finishes the access with a run of low idle slots, so that the clock may be stopped safely afterwards.

The serial clock is derived from the system clock through a divider that can be set at run time. The engine changes the data line only while the serial clock is low, and it samples the target on the rising edge. The acknowledge code goes back to the host unchanged. A WAIT, FAULT or unrecognised code cuts the access short after one turnaround slot. Deciding whether to retry is left to the logic above the engine.

Top module: `swd_host_engine`

## Requirements
- R1: The request is sent in slots 0 to 7, least significant bit first, as the byte {park=1, stop=0, parity, A3, A2, read, port-select, start=1} from bit 7 down to bit 0. `cmd_addr[0]` is A2, `cmd_addr[1]` is A3, and the parity bit is the XOR of port-select, read, A2 and A3. So a read of debug-port register 0 is 0xA5 and a write is 0x81.
- R2: Every slot lasts 2*(clk_div+1) system clocks: a low half, then a high half. `swclk` stays low whenever `busy` is 0.
- R3: `swdio_out` changes only in cycles where `swclk` is low. The target value on `swdio_in` is taken at the rising edge of `swclk`.
- R4: Slot 8 is a turnaround slot. `swdio_oe` is 0 in slots 8 to 11, and the value the target puts on the line in slot 8 has no effect on any result.
- R5: Slots 9 to 11 carry the acknowledge. `ack_code[i]` holds the wire bit of slot 9+i, so OK is 3'b001, WAIT is 3'b010 and FAULT is 3'b100.
- R6: On a read with OK, slots 12 to 43 carry data least significant bit first into `rd_data`. Slot 44 carries parity and slot 45 is a turnaround. `swdio_oe` is 0 from slot 12 to slot 45, and the access is 46 slots before the idle tail.
- R7: Parity is even over the 32 data bits. `par_err` is 1 after a read with OK exactly when the received parity bit differs from the XOR of the received data. In every other case it is 0.
- R8: On a write with OK, slot 12 is a turnaround with `swdio_oe` 0. The host then drives `cmd_wdata` least significant bit first in slots 13 to 44 and its XOR in slot 45. The access is 46 slots.
- R9: Any acknowledge other than OK skips the data phase. One turnaround slot (slot 12) follows, so the access is 13 slots before the idle tail, and `rd_data` reads 0.
- R10: Every access ends with IDLE_CYC (at least 8) slots in which the line is driven low. Then `done` pulses for one system clock, `busy` falls in the same cycle, and the results hold until the next command.
- R11: A `cmd_start` pulse while `busy` is 1 is ignored. It alters neither the running access nor what follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Half-slot length minus one, in system clocks |
| cmd_start | input | 1 | Pulse that launches one access when idle |
| cmd_apndp | input | 1 | Port select: 0 debug port, 1 access port |
| cmd_rnw | input | 1 | 1 for read, 0 for write |
| cmd_addr | input | 2 | Register address bits A3 (bit 1) and A2 (bit 0) |
| cmd_wdata | input | 32 | Data for a write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse at the end of an access |
| ack_code | output | 3 | Acknowledge as received, wire order in bit order |
| rd_data | output | 32 | Read data, 0 unless a read ended with OK |
| par_err | output | 1 | Read parity mismatch |
| swclk | output | 1 | Serial debug clock |
| swdio_out | output | 1 | Data line value when the host drives it |
| swdio_oe | output | 1 | Host drive enable for the data line |
| swdio_in | input | 1 | Data line value as seen at the pad |

## Verification
The bench runs all sixteen combinations of port select, direction and address under three divider settings. This tells apart every request bit and parity case, and it also checks the slot period. A behavioural target answers with data built from a multiplicative sequence, and it flips the parity bit on alternate reads, which separates good parity from corrupted parity. WAIT, FAULT and an all-ones acknowledge are tried for both directions, so the shortened path can be told apart from the data path. Finally, a second start pulse in the middle of an access shows that a busy engine leaves the wire pattern unchanged.

// File: rtl/swdh_pkg.sv
package swdh_pkg;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_REQ,
      PH_TRN_A,
      PH_ACK,
      PH_RDATA,
      PH_RPAR,
      PH_TRN_B,
      PH_WDATA,
      PH_WPAR,
      PH_TAIL
   } phase_t;

   localparam logic [2:0] ACK_OK    = 3'b001;
   localparam logic [2:0] ACK_WAIT  = 3'b010;
   localparam logic [2:0] ACK_FAULT = 3'b100;

   localparam int unsigned DATA_W   = 32;
   localparam int unsigned REQ_W    = 8;
   localparam int unsigned ACK_W    = 3;

   typedef struct packed {
      logic       apndp;
      logic       rnw;
      logic [1:0] addr;
   } req_t;

endpackage

// File: rtl/swdh_clkgen.sv
module swdh_clkgen #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             swclk,
   output logic             rise,
   output logic             fall
);

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("swdh_clkgen: DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt;
   logic             wrap;

   assign wrap = run && (cnt == div);
   assign rise = wrap && !swclk;
   assign fall = wrap && swclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         swclk <= 1'b0;
      end else if (!run) begin
         cnt   <= '0;
         swclk <= 1'b0;
      end else if (wrap) begin
         cnt   <= '0;
         swclk <= !swclk;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/swdh_reqgen.sv
module swdh_reqgen
   import swdh_pkg::*;
(
   input  req_t             req,
   output logic [REQ_W-1:0] req_byte
);

   logic hdr_par;

   assign hdr_par = req.apndp ^ req.rnw ^ req.addr[0] ^ req.addr[1];

   // bit 0 goes out first
   always_comb begin
      req_byte[0] = 1'b1;
      req_byte[1] = req.apndp;
      req_byte[2] = req.rnw;
      req_byte[3] = req.addr[0];
      req_byte[4] = req.addr[1];
      req_byte[5] = hdr_par;
      req_byte[6] = 1'b0;
      req_byte[7] = 1'b1;
   end

endmodule

// File: rtl/swdh_seq.sv
module swdh_seq
   import swdh_pkg::*;
#(
   parameter int unsigned IDLE_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  req_t              req_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic              rise,
   input  logic              fall,
   input  logic              sdi,
   output req_t              req_q,
   input  logic [REQ_W-1:0]  req_byte,
   output logic              busy,
   output logic              done,
   output logic [ACK_W-1:0]  ack_code,
   output logic [DATA_W-1:0] rd_data,
   output logic              par_err,
   output logic              sdo,
   output logic              sdo_en
);

   localparam int unsigned SPAN  = (IDLE_CYC > DATA_W) ? IDLE_CYC : DATA_W;
   localparam int unsigned CNT_W = $clog2(SPAN);
   localparam logic [CNT_W-1:0] LAST_REQ  = CNT_W'(REQ_W - 1);
   localparam logic [CNT_W-1:0] LAST_ACK  = CNT_W'(ACK_W - 1);
   localparam logic [CNT_W-1:0] LAST_DAT  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_TAIL = CNT_W'(IDLE_CYC - 1);

   generate
      if (IDLE_CYC < 8) begin : g_bad_tail
         $error("swdh_seq: IDLE_CYC must be at least 8");
      end
   endgenerate

   phase_t              ph;
   logic [CNT_W-1:0]    bcnt;
   logic [DATA_W-1:0]   wd_q;
   logic [DATA_W-1:0]   rd_sh;
   logic [ACK_W-1:0]    ack_sh;
   logic                par_rx;
   logic                wr_go;
   logic                ack_ok;
   logic                rd_ok;

   assign ack_ok = (ack_sh == ACK_OK);
   assign rd_ok  = ack_ok && req_q.rnw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         bcnt     <= '0;
         req_q    <= '0;
         wd_q     <= '0;
         rd_sh    <= '0;
         ack_sh   <= '0;
         par_rx   <= 1'b0;
         wr_go    <= 1'b0;
         busy     <= 1'b0;
         done     <= 1'b0;
         ack_code <= '0;
         rd_data  <= '0;
         par_err  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (launch) begin
            ph     <= PH_REQ;
            bcnt   <= '0;
            req_q  <= req_in;
            wd_q   <= wdata_in;
            ack_sh <= '0;
            wr_go  <= 1'b0;
            busy   <= 1'b1;
         end else if (rise) begin
            unique case (ph)
               PH_ACK:   ack_sh[bcnt[1:0]] <= sdi;
               PH_RDATA: rd_sh[bcnt[4:0]]  <= sdi;
               PH_RPAR:  par_rx            <= sdi;
               default:  ;
            endcase
         end else if (fall) begin
            unique case (ph)
               PH_REQ: begin
                  if (bcnt == LAST_REQ) begin
                     ph   <= PH_TRN_A;
                     bcnt <= '0;
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               PH_TRN_A: begin
                  ph   <= PH_ACK;
                  bcnt <= '0;
               end
               PH_ACK: begin
                  if (bcnt == LAST_ACK) begin
                     bcnt <= '0;
                     if (rd_ok) begin
                        ph <= PH_RDATA;
                     end else begin
                        ph    <= PH_TRN_B;
                        wr_go <= ack_ok;
                     end
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               PH_RDATA: begin
                  if (bcnt == LAST_DAT) begin
                     ph   <= PH_RPAR;
                     bcnt <= '0;
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               PH_RPAR: begin
                  ph <= PH_TRN_B;
               end
               PH_TRN_B: begin
                  bcnt  <= '0;
                  wr_go <= 1'b0;
                  ph    <= wr_go ? PH_WDATA : PH_TAIL;
               end
               PH_WDATA: begin
                  if (bcnt == LAST_DAT) begin
                     ph   <= PH_WPAR;
                     bcnt <= '0;
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               PH_WPAR: begin
                  ph   <= PH_TAIL;
                  bcnt <= '0;
               end
               PH_TAIL: begin
                  if (bcnt == LAST_TAIL) begin
                     ph       <= PH_IDLE;
                     bcnt     <= '0;
                     busy     <= 1'b0;
                     done     <= 1'b1;
                     ack_code <= ack_sh;
                     rd_data  <= rd_ok ? rd_sh : '0;
                     par_err  <= rd_ok && ((^rd_sh) != par_rx);
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               default: ph <= PH_IDLE;
            endcase
         end
      end
   end

   // line drive follows the registered phase, so it moves on the fall event
   always_comb begin
      sdo    = 1'b0;
      sdo_en = 1'b1;
      unique case (ph)
         PH_REQ:   sdo = req_byte[bcnt[2:0]];
         PH_WDATA: sdo = wd_q[bcnt[4:0]];
         PH_WPAR:  sdo = ^wd_q;
         PH_TRN_A, PH_ACK, PH_RDATA, PH_RPAR, PH_TRN_B: sdo_en = 1'b0;
         default:  ;
      endcase
   end

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
   import swdh_pkg::*;
#(
   parameter int unsigned DIV_W    = 8,
   parameter int unsigned IDLE_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic              cmd_start,
   input  logic              cmd_apndp,
   input  logic              cmd_rnw,
   input  logic [1:0]        cmd_addr,
   input  logic [31:0]       cmd_wdata,
   output logic              busy,
   output logic              done,
   output logic [2:0]        ack_code,
   output logic [31:0]       rd_data,
   output logic              par_err,
   output logic              swclk,
   output logic              swdio_out,
   output logic              swdio_oe,
   input  logic              swdio_in
);

   req_t             req_in;
   req_t             req_q;
   logic [REQ_W-1:0] req_byte;
   logic             launch;
   logic             rise;
   logic             fall;

   assign req_in = '{apndp: cmd_apndp, rnw: cmd_rnw, addr: cmd_addr};
   assign launch = cmd_start && !busy;

   swdh_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .div   (clk_div),
      .swclk (swclk),
      .rise  (rise),
      .fall  (fall)
   );

   swdh_reqgen u_req (
      .req      (req_q),
      .req_byte (req_byte)
   );

   swdh_seq #(.IDLE_CYC(IDLE_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .req_in   (req_in),
      .wdata_in (cmd_wdata),
      .rise     (rise),
      .fall     (fall),
      .sdi      (swdio_in),
      .req_q    (req_q),
      .req_byte (req_byte),
      .busy     (busy),
      .done     (done),
      .ack_code (ack_code),
      .rd_data  (rd_data),
      .par_err  (par_err),
      .sdo      (swdio_out),
      .sdo_en   (swdio_oe)
   );

endmodule

// File: rtl/swdh_chk.sv
module swdh_chk #(
   parameter int unsigned IDLE_CYC = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_start,
   input logic       busy,
   input logic       done,
   input logic       swclk,
   input logic       swdio_out,
   input logic       swdio_oe,
   input logic [2:0] ack_code,
   input logic       par_err
);

   localparam logic [7:0] LEN_FULL  = 8'(46 + IDLE_CYC);
   localparam logic [7:0] LEN_SHORT = 8'(13 + IDLE_CYC);

   logic       clk_q;
   logic [7:0] rises;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q <= 1'b0;
         rises <= '0;
      end else begin
         clk_q <= swclk;
         if (cmd_start && !busy)
            rises <= '0;
         else if (swclk && !clk_q)
            rises <= rises + 1'b1;
      end
   end

   assert_dout_low_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(swdio_out) |-> !swclk);

   assert_clk_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !swclk);

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_ack_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !swclk && rises >= 8'd8 && rises <= 8'd11) |-> !swdio_oe);

   assert_frame_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rises == ((ack_code == 3'b001) ? LEN_FULL : LEN_SHORT)));

   assert_perr_on_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
      par_err |-> (ack_code == 3'b001));

endmodule

bind swd_host_engine swdh_chk #(.IDLE_CYC(IDLE_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_start (cmd_start),
   .busy      (busy),
   .done      (done),
   .swclk     (swclk),
   .swdio_out (swdio_out),
   .swdio_oe  (swdio_oe),
   .ack_code  (ack_code),
   .par_err   (par_err)
);

// File: tb/tb_swd_host_engine.sv
`timescale 1ns/1ps
module tb_swd_host_engine;

   localparam int TAIL = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  clk_div = 8'd0;
   logic        cmd_start = 1'b0;
   logic        cmd_apndp = 1'b0;
   logic        cmd_rnw = 1'b0;
   logic [1:0]  cmd_addr = 2'b00;
   logic [31:0] cmd_wdata = '0;
   logic        busy, done, par_err, swclk, swdio_out, swdio_oe;
   logic [2:0]  ack_code;
   logic [31:0] rd_data;
   logic        swdio_in = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #4 clk = !clk;

   swd_host_engine #(.DIV_W(8), .IDLE_CYC(TAIL)) dut (
      .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .cmd_start(cmd_start),
      .cmd_apndp(cmd_apndp), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr),
      .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .ack_code(ack_code),
      .rd_data(rd_data), .par_err(par_err), .swclk(swclk),
      .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in)
   );

   // target model
   logic [2:0]  t_ack;
   logic [31:0] t_rd;
   logic        t_bad;
   logic        t_rnw;
   logic        hb [0:127];
   logic        ho [0:127];
   realtime     tr [0:127];
   int          r = 0;
   int          viol = 0;

   function automatic logic tbit(int s);
      if (s == 8) return 1'b1;
      if (s >= 9 && s <= 11) return t_ack[s-9];
      if (t_ack == 3'b001 && t_rnw) begin
         if (s >= 12 && s <= 43) return t_rd[s-12];
         if (s == 44) return (^t_rd) ^ t_bad;
         if (s == 45) return 1'b1;
      end
      if (s == 12) return 1'b1;
      return 1'b0;
   endfunction

   always @(posedge swclk) begin
      if (r < 128) begin
         hb[r] = swdio_out;
         ho[r] = swdio_oe;
         tr[r] = $realtime;
      end
      r = r + 1;
   end

   always @(negedge swclk) swdio_in = tbit(r);

   always @(swdio_out) begin
      #1;
      if (swclk) viol = viol + 1;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic run_txn(input logic ap, input logic rw, input logic [1:0] ad,
                          input logic [31:0] wd, input logic [2:0] ak,
                          input logic [31:0] rv, input logic bad,
                          input logic [7:0] dv, input bit poke);
      logic [7:0]  exp_req, got_req;
      logic [31:0] got_wd;
      logic        oe_ok;
      bit          ok_ack;
      int          len, guard;
      clk_div = dv; t_ack = ak; t_rd = rv; t_bad = bad; t_rnw = rw;
      r = 0; swdio_in = 1'b0; viol = 0;
      @(negedge clk);
      cmd_apndp = ap; cmd_rnw = rw; cmd_addr = ad; cmd_wdata = wd; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      if (poke) begin
         repeat (40) @(negedge clk);
         cmd_apndp = !ap; cmd_rnw = !rw; cmd_addr = ~ad; cmd_wdata = ~wd; cmd_start = 1'b1;
         @(negedge clk);
         cmd_start = 1'b0;
      end
      guard = 0;
      while (!done && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      ok_ack  = (ak == 3'b001);
      len     = (ok_ack ? 46 : 13) + TAIL;
      exp_req = {1'b1, 1'b0, ap ^ rw ^ ad[0] ^ ad[1], ad[1], ad[0], rw, ap, 1'b1};
      got_req = '0;
      oe_ok   = 1'b1;
      for (int i = 0; i < 8; i++) begin
         got_req[i] = hb[i];
         oe_ok = oe_ok & ho[i];
      end
      chk(got_req == exp_req && oe_ok, "R1 request byte", 64'(got_req), 64'(exp_req));
      chk(!ho[8] && !ho[9] && !ho[10] && !ho[11], "R4 turnaround/ack released",
          64'({ho[8], ho[9], ho[10], ho[11]}), 64'd0);
      chk(ack_code == ak, "R5 ack code", 64'(ack_code), 64'(ak));
      chk(r == len, ok_ack ? (rw ? "R6 read length" : "R8 write length") : "R9 short length",
          64'(r), 64'(len));
      chk(tr[1] - tr[0] == 16.0 * (dv + 1), "R2 slot period",
          64'(int'(tr[1] - tr[0])), 64'(16 * (dv + 1)));
      chk(!busy && !swclk, "R2 clock parked after done", 64'({busy, swclk}), 64'd0);
      chk(viol == 0, "R3 out changes with clock low", 64'(viol), 64'd0);
      if (ok_ack && rw) begin
         chk(rd_data == rv, "R6 read data", 64'(rd_data), 64'(rv));
         chk(par_err == bad, "R7 parity error flag", 64'(par_err), 64'(bad));
         oe_ok = 1'b0;
         for (int i = 12; i <= 45; i++) oe_ok = oe_ok | ho[i];
         chk(!oe_ok, "R6 line released in data phase", 64'(oe_ok), 64'd0);
      end else begin
         chk(par_err == 1'b0, "R7 no parity error", 64'(par_err), 64'd0);
      end
      if (!ok_ack) chk(rd_data == '0, "R9 read data cleared", 64'(rd_data), 64'd0);
      if (ok_ack && !rw) begin
         got_wd = '0;
         oe_ok  = 1'b1;
         for (int i = 0; i < 32; i++) begin
            got_wd[i] = hb[13+i];
            oe_ok = oe_ok & ho[13+i];
         end
         chk(!ho[12], "R8 turnaround after ack", 64'(ho[12]), 64'd0);
         chk(got_wd == wd && oe_ok && ho[45], "R8 write data", 64'(got_wd), 64'(wd));
         chk(hb[45] == ^wd, "R8 write parity", 64'(hb[45]), 64'(^wd));
      end
      oe_ok = 1'b1;
      for (int i = len - TAIL; i < len; i++) oe_ok = oe_ok & ho[i] & !hb[i];
      chk(oe_ok, "R10 idle tail low and driven", 64'(oe_ok), 64'd1);
      if (poke) begin
         repeat (20) @(negedge clk);
         chk(!busy && r == len, "R11 start while busy ignored", 64'({busy, 8'(r)}), 64'(len));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired got=busy expected=idle");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !swclk && swdio_oe && !swdio_out && ack_code == 3'b000,
          "R10 reset state", 64'({busy, done, swclk, swdio_oe, swdio_out}), 64'b00010);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      for (int d = 0; d < 3; d++) begin
         for (int k = 0; k < 16; k++) begin
            logic [31:0] v;
            v = 32'h9E37_79B9 * (k + 1 + 16 * d);
            run_txn(k[0], k[1], k[3:2], ~v, 3'b001, v, k[0] ^ k[2],
                    (d == 2) ? 8'd3 : 8'(d), 1'b0);
         end
      end
      run_txn(1'b0, 1'b1, 2'b00, 32'h0, 3'b010, 32'hFFFF_FFFF, 1'b0, 8'd1, 1'b0);
      run_txn(1'b1, 1'b0, 2'b01, 32'h1E, 3'b010, 32'h0, 1'b0, 8'd0, 1'b0);
      run_txn(1'b0, 1'b1, 2'b10, 32'h0, 3'b100, 32'h1234_5678, 1'b0, 8'd2, 1'b0);
      run_txn(1'b0, 1'b0, 2'b11, 32'hDEAD_BEEF, 3'b100, 32'h0, 1'b0, 8'd0, 1'b0);
      run_txn(1'b1, 1'b1, 2'b11, 32'h0, 3'b111, 32'hA5A5_5A5A, 1'b0, 8'd1, 1'b0);
      run_txn(1'b0, 1'b0, 2'b00, 32'h0000_001E, 3'b001, 32'h0, 1'b0, 8'd0, 1'b0);
      run_txn(1'b0, 1'b1, 2'b00, 32'h0, 3'b001, 32'h2BA0_1477, 1'b0, 8'd0, 1'b0);
      run_txn(1'b1, 1'b0, 2'b10, 32'hCAFE_F00D, 3'b001, 32'h0, 1'b0, 8'd1, 1'b1);
      run_txn(1'b0, 1'b1, 2'b01, 32'h0, 3'b001, 32'h8000_0001, 1'b1, 8'd1, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule